// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the device-side serial receiver of a NOR flash. It follows each command frame on the serial clock, chip select and data-in lines, assembles the opcode, a 24-bit address and any payload bytes, and sorts the opcode into a command class. For read-type commands it shifts array data or a status byte out on the data-out line. For every accepted frame it hands a single-cycle command strobe to a storage back end. The back end owns the array, the status registers and all program and erase timing.

The serial lines are sampled by a fast system clock through a synchronizer, and edges of the serial clock are found in that domain. Writes, programs, erases and the write-enable controls are accepted only when the frame ends on a whole byte and carries a full header. While the back end reports busy, every opcode except the first status read is dropped.

Top module: `flash_cmd_frontend`

## Requirements
- R1: After reset, spi_do, spi_do_oe, wb_valid_o and cmd_valid_o are 0 and rd_addr_o is 0.
- R2: A frame starts when spi_cs_n falls. The first eight bits, taken on rising serial clock edges MSB first, form the opcode. When spi_cs_n rises, an accepted frame gives one cmd_valid_o pulse that carries cmd_op_o and cmd_class_o. The class codes are: 1 read (03h, 0Bh), 2 status read (05h, 35h), 3 status write (01h), 4 program (02h), 5 erase (20h, 52h, D8h, 60h, C7h), 6 control (06h, 04h).
- R3: Frames behave the same when the serial clock idles low (mode 0) or idles high (mode 3) at the chip-select edges.
- R4: Addressed commands (03h, 0Bh, 02h, 20h, 52h, D8h) take bytes 2 to 4 as a 24-bit address, high byte first, and report it on cmd_addr_o. Commands without an address report 0. During a read, rd_addr_o starts at that address, steps by one for each byte sent and wraps from FFFFFFh to 000000h.
- R5: Read data (rd_data_i at rd_addr_o) is shifted out MSB first on falling serial clock edges. For 03h it starts right after the last address bit. For 0Bh it starts after one further dummy byte.
- R6: 05h sends status1_i and 35h sends status2_i, and the byte repeats for as long as the clock runs.
- R7: A read or status read may end after any bit and is still accepted. cmd_nbytes_o is the number of whole bytes received after the header.
- R8: A status write, program, erase or control frame is discarded (no cmd_valid_o) if spi_cs_n rises after a partial byte, or before the full header has arrived. The header is 4 bytes for addressed commands and 1 byte otherwise.
- R9: For 01h and 02h, each whole byte after the header gives one wb_valid_o pulse with that byte on wb_data_o. cmd_nbytes_o counts these bytes, and the command strobe follows the last of them.
- R10: If busy_i is high in the cycle the opcode completes, any opcode other than 05h is dropped: no strobe, no payload pulses and no data-out drive. 05h still works normally.
- R11: An opcode outside the listed set gives no strobe and no data-out drive.
- R12: spi_do_oe is high only during the output phase of an accepted read or status read. It clears within a few system cycles after spi_cs_n rises. spi_do is 0 whenever spi_do_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_di | input | 1 | Serial data in |
| spi_do | output | 1 | Serial data out |
| spi_do_oe | output | 1 | Output enable for spi_do |
| busy_i | input | 1 | Back end is programming or erasing |
| status1_i | input | 8 | First status register value |
| status2_i | input | 8 | Second status register value |
| rd_addr_o | output | ADDR_W | Array read address |
| rd_data_i | input | 8 | Array byte at rd_addr_o |
| wb_valid_o | output | 1 | Payload byte pulse |
| wb_data_o | output | 8 | Payload byte |
| cmd_valid_o | output | 1 | Command strobe at frame end |
| cmd_op_o | output | 8 | Opcode of the strobed command |
| cmd_class_o | output | 3 | Class code of the strobed command |
| cmd_addr_o | output | ADDR_W | Address of the strobed command |
| cmd_nbytes_o | output | CNT_W | Whole bytes after the header |

## Verification
Two events can collide: the capture of the final payload byte and the end of the frame. On the synchronized lines they can land in consecutive system cycles. The bench provokes this with a mode-3 program frame whose chip select rises one system clock after the last rising serial clock edge. The scoreboard must then see every payload pulse before the single command strobe, with the full byte count. A checker property requires that a payload pulse and a command strobe never share a cycle.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

    localparam int ADDR_W     = 24;
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int OPC_W      = 8;

    localparam logic [OPC_W-1:0] OPC_READ     = 8'h03;
    localparam logic [OPC_W-1:0] OPC_READ_FST = 8'h0B;
    localparam logic [OPC_W-1:0] OPC_RDSR1    = 8'h05;
    localparam logic [OPC_W-1:0] OPC_RDSR2    = 8'h35;
    localparam logic [OPC_W-1:0] OPC_WRSR     = 8'h01;
    localparam logic [OPC_W-1:0] OPC_PROG     = 8'h02;
    localparam logic [OPC_W-1:0] OPC_ER4K     = 8'h20;
    localparam logic [OPC_W-1:0] OPC_ER32K    = 8'h52;
    localparam logic [OPC_W-1:0] OPC_ER64K    = 8'hD8;
    localparam logic [OPC_W-1:0] OPC_ERALL_A  = 8'h60;
    localparam logic [OPC_W-1:0] OPC_ERALL_B  = 8'hC7;
    localparam logic [OPC_W-1:0] OPC_WEN      = 8'h06;
    localparam logic [OPC_W-1:0] OPC_WDIS     = 8'h04;

    typedef enum logic [2:0] {
        CLS_NONE    = 3'd0,
        CLS_READ    = 3'd1,
        CLS_STAT_RD = 3'd2,
        CLS_STAT_WR = 3'd3,
        CLS_PROG    = 3'd4,
        CLS_ERASE   = 3'd5,
        CLS_CTRL    = 3'd6
    } cmd_class_e;

    typedef struct packed {
        cmd_class_e cls;
        logic [2:0] hdr_len;   // bytes up to the payload, opcode included
        logic       addr_en;
        logic       stat_hi;   // selects the second status byte
    } op_info_t;

    localparam op_info_t INFO_IDLE = '{cls: CLS_NONE, hdr_len: 3'd1, addr_en: 1'b0, stat_hi: 1'b0};

    function automatic op_info_t op_decode(input logic [OPC_W-1:0] opc);
        op_info_t r;
        r = INFO_IDLE;
        case (opc)
            OPC_READ:     r = '{cls: CLS_READ,    hdr_len: 3'(1 + ADDR_BYTES),     addr_en: 1'b1, stat_hi: 1'b0};
            OPC_READ_FST: r = '{cls: CLS_READ,    hdr_len: 3'(2 + ADDR_BYTES),     addr_en: 1'b1, stat_hi: 1'b0};
            OPC_RDSR1:    r = '{cls: CLS_STAT_RD, hdr_len: 3'd1,                   addr_en: 1'b0, stat_hi: 1'b0};
            OPC_RDSR2:    r = '{cls: CLS_STAT_RD, hdr_len: 3'd1,                   addr_en: 1'b0, stat_hi: 1'b1};
            OPC_WRSR:     r = '{cls: CLS_STAT_WR, hdr_len: 3'd1,                   addr_en: 1'b0, stat_hi: 1'b0};
            OPC_PROG:     r = '{cls: CLS_PROG,    hdr_len: 3'(1 + ADDR_BYTES),     addr_en: 1'b1, stat_hi: 1'b0};
            OPC_ER4K,
            OPC_ER32K,
            OPC_ER64K:    r = '{cls: CLS_ERASE,   hdr_len: 3'(1 + ADDR_BYTES),     addr_en: 1'b1, stat_hi: 1'b0};
            OPC_ERALL_A,
            OPC_ERALL_B:  r = '{cls: CLS_ERASE,   hdr_len: 3'd1,                   addr_en: 1'b0, stat_hi: 1'b0};
            OPC_WEN,
            OPC_WDIS:     r = '{cls: CLS_CTRL,    hdr_len: 3'd1,                   addr_en: 1'b0, stat_hi: 1'b0};
            default:      r = INFO_IDLE;
        endcase
        return r;
    endfunction

    // Classes that alter the device and so must end on a byte boundary
    function automatic logic needs_whole_byte(input cmd_class_e c);
        return (c == CLS_STAT_WR) || (c == CLS_PROG) || (c == CLS_ERASE) || (c == CLS_CTRL);
    endfunction

    // Classes whose bytes after the header are forwarded to the back end
    function automatic logic carries_payload(input cmd_class_e c);
        return (c == CLS_STAT_WR) || (c == CLS_PROG);
    endfunction

endpackage

// File: rtl/flash_fe_sync.sv
module flash_fe_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_raw,
    input  logic cs_n_raw,
    input  logic di_raw,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_active,
    output logic cs_end,
    output logic di_s
);
    // lane order {sclk, cs_n, di}
    localparam logic [2:0] IDLE_LANES = 3'b010;

    logic [2:0] chain [SYNC_STAGES];
    logic       sclk_prev;
    logic       cs_prev;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= IDLE_LANES;
                else     chain[g] <= {sclk_raw, cs_n_raw, di_raw};
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= IDLE_LANES;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev <= 1'b0;
            cs_prev   <= 1'b1;
        end else begin
            sclk_prev <= chain[SYNC_STAGES-1][2];
            cs_prev   <= chain[SYNC_STAGES-1][1];
        end
    end

    logic sclk_s, cs_s;
    assign sclk_s    = chain[SYNC_STAGES-1][2];
    assign cs_s      = chain[SYNC_STAGES-1][1];
    assign di_s      = chain[SYNC_STAGES-1][0];
    assign cs_active = ~cs_s;
    assign cs_end    = cs_s & ~cs_prev;
    assign sclk_rise = sclk_s & ~sclk_prev & ~cs_s;
    assign sclk_fall = ~sclk_s & sclk_prev & ~cs_s;
endmodule

// File: rtl/flash_fe_rx.sv
module flash_fe_rx #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_active,
    input  logic             sclk_rise,
    input  logic             di_s,
    output logic             byte_done,
    output logic [7:0]       byte_val,
    output logic [CNT_W-1:0] byte_idx,
    output logic [CNT_W-1:0] byte_cnt,
    output logic [2:0]       bit_idx
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [6:0] shift_q;

    assign byte_done = sclk_rise && (bit_idx == 3'd7);
    assign byte_val  = {shift_q, di_s};
    assign byte_idx  = byte_cnt;

    always_ff @(posedge clk) begin
        if (rst || !cs_active) begin
            shift_q  <= '0;
            bit_idx  <= '0;
            byte_cnt <= '0;
        end else if (sclk_rise) begin
            shift_q <= {shift_q[5:0], di_s};
            bit_idx <= bit_idx + 3'd1;
            if (bit_idx == 3'd7 && byte_cnt != CNT_MAX)
                byte_cnt <= byte_cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/flash_fe_cmd.sv
module flash_fe_cmd
    import flash_fe_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_active,
    input  logic              cs_end,
    input  logic              busy_i,
    input  logic              byte_done,
    input  logic [7:0]        byte_val,
    input  logic [CNT_W-1:0]  byte_idx,
    input  logic [CNT_W-1:0]  byte_cnt,
    input  logic [2:0]        bit_idx,
    input  logic              tx_load,
    output logic              out_en,
    output logic              stat_hi,
    output cmd_class_e        cur_cls,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wb_valid,
    output logic [7:0]        wb_data,
    output logic              cmd_valid,
    output logic [OPC_W-1:0]  cmd_op,
    output cmd_class_e        cmd_cls,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [CNT_W-1:0]  cmd_nbytes
);
    logic [OPC_W-1:0]  op_q;
    op_info_t          info_q;
    logic              drop_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  hdr_ext;
    op_info_t          dec_now;
    logic              drop_now;
    logic              frame_ok;
    logic [CNT_W-1:0]  payload_cnt;

    assign hdr_ext  = CNT_W'(info_q.hdr_len);
    assign dec_now  = op_decode(byte_val);
    assign drop_now = busy_i && (byte_val != OPC_RDSR1);
    assign stat_hi  = info_q.stat_hi;
    assign cur_cls  = info_q.cls;

    // Frame state, cleared whenever chip select is inactive
    always_ff @(posedge clk) begin
        if (rst || !cs_active) begin
            op_q     <= '0;
            info_q   <= INFO_IDLE;
            drop_q   <= 1'b0;
            addr_q   <= '0;
            rd_addr  <= '0;
            out_en   <= 1'b0;
            wb_valid <= 1'b0;
            wb_data  <= '0;
        end else begin
            wb_valid <= 1'b0;
            if (byte_done) begin
                if (byte_idx == '0) begin
                    op_q   <= byte_val;
                    info_q <= dec_now;
                    drop_q <= drop_now;
                    if (dec_now.cls == CLS_STAT_RD && !drop_now)
                        out_en <= 1'b1;
                end else begin
                    if (info_q.addr_en && byte_idx <= CNT_W'(ADDR_BYTES))
                        addr_q <= {addr_q[ADDR_W-9:0], byte_val};
                    if (info_q.cls == CLS_READ && byte_idx == CNT_W'(ADDR_BYTES))
                        rd_addr <= {addr_q[ADDR_W-9:0], byte_val};
                    if (info_q.cls == CLS_READ && !drop_q && byte_idx == hdr_ext - CNT_W'(1))
                        out_en <= 1'b1;
                    if (carries_payload(info_q.cls) && !drop_q && byte_idx >= hdr_ext) begin
                        wb_valid <= 1'b1;
                        wb_data  <= byte_val;
                    end
                end
            end else if (tx_load && info_q.cls == CLS_READ) begin
                rd_addr <= rd_addr + ADDR_W'(1);
            end
        end
    end

    // Acceptance at frame end
    always_comb begin
        frame_ok = (byte_cnt != '0) && !drop_q && (info_q.cls != CLS_NONE);
        if (needs_whole_byte(info_q.cls))
            frame_ok = frame_ok && (bit_idx == 3'd0) && (byte_cnt >= hdr_ext);
        payload_cnt = (byte_cnt > hdr_ext) ? (byte_cnt - hdr_ext) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid  <= 1'b0;
            cmd_op     <= '0;
            cmd_cls    <= CLS_NONE;
            cmd_addr   <= '0;
            cmd_nbytes <= '0;
        end else begin
            cmd_valid <= cs_end && frame_ok;
            if (cs_end && frame_ok) begin
                cmd_op     <= op_q;
                cmd_cls    <= info_q.cls;
                cmd_addr   <= addr_q;
                cmd_nbytes <= payload_cnt;
            end
        end
    end
endmodule

// File: rtl/flash_fe_tx.sv
module flash_fe_tx (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_active,
    input  logic       out_en,
    input  logic       sclk_fall,
    input  logic [7:0] load_byte,
    output logic       tx_load,
    output logic       do_bit,
    output logic       do_oe
);
    logic [7:0] sh_q;
    logic [2:0] left_q;

    assign tx_load = sclk_fall && out_en && (left_q == 3'd0);
    assign do_bit  = sh_q[7];

    always_ff @(posedge clk) begin
        if (rst || !cs_active || !out_en) begin
            sh_q   <= '0;
            left_q <= '0;
            do_oe  <= 1'b0;
        end else if (sclk_fall) begin
            if (left_q == 3'd0) begin
                sh_q   <= load_byte;
                left_q <= 3'd7;
                do_oe  <= 1'b1;
            end else begin
                sh_q   <= {sh_q[6:0], 1'b0};
                left_q <= left_q - 3'd1;
            end
        end
    end
endmodule

// File: rtl/flash_cmd_frontend.sv
module flash_cmd_frontend
    import flash_fe_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_di,
    output logic              spi_do,
    output logic              spi_do_oe,
    input  logic              busy_i,
    input  logic [7:0]        status1_i,
    input  logic [7:0]        status2_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i,
    output logic              wb_valid_o,
    output logic [7:0]        wb_data_o,
    output logic              cmd_valid_o,
    output logic [OPC_W-1:0]  cmd_op_o,
    output logic [2:0]        cmd_class_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic [CNT_W-1:0]  cmd_nbytes_o
);
    logic sclk_rise, sclk_fall, cs_active, cs_end, di_s;
    logic byte_done;
    logic [7:0] byte_val;
    logic [CNT_W-1:0] byte_idx, byte_cnt;
    logic [2:0] bit_idx;
    logic tx_load, out_en, stat_hi;
    cmd_class_e cur_cls, cmd_cls;
    logic [7:0] load_byte;

    flash_fe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .sclk_raw(spi_sclk), .cs_n_raw(spi_cs_n), .di_raw(spi_di),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_active(cs_active), .cs_end(cs_end), .di_s(di_s)
    );

    flash_fe_rx #(.CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst(rst), .cs_active(cs_active),
        .sclk_rise(sclk_rise), .di_s(di_s),
        .byte_done(byte_done), .byte_val(byte_val),
        .byte_idx(byte_idx), .byte_cnt(byte_cnt), .bit_idx(bit_idx)
    );

    flash_fe_cmd #(.CNT_W(CNT_W)) u_cmd (
        .clk(clk), .rst(rst), .cs_active(cs_active), .cs_end(cs_end),
        .busy_i(busy_i), .byte_done(byte_done), .byte_val(byte_val),
        .byte_idx(byte_idx), .byte_cnt(byte_cnt), .bit_idx(bit_idx),
        .tx_load(tx_load), .out_en(out_en), .stat_hi(stat_hi),
        .cur_cls(cur_cls), .rd_addr(rd_addr_o),
        .wb_valid(wb_valid_o), .wb_data(wb_data_o),
        .cmd_valid(cmd_valid_o), .cmd_op(cmd_op_o), .cmd_cls(cmd_cls),
        .cmd_addr(cmd_addr_o), .cmd_nbytes(cmd_nbytes_o)
    );

    always_comb begin
        if (cur_cls == CLS_READ) load_byte = rd_data_i;
        else if (stat_hi)        load_byte = status2_i;
        else                     load_byte = status1_i;
    end

    flash_fe_tx u_tx (
        .clk(clk), .rst(rst), .cs_active(cs_active), .out_en(out_en),
        .sclk_fall(sclk_fall), .load_byte(load_byte),
        .tx_load(tx_load), .do_bit(spi_do), .do_oe(spi_do_oe)
    );

    assign cmd_class_o = cmd_cls;
endmodule

// File: rtl/flash_cmd_frontend_chk.sv
module flash_cmd_frontend_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       spi_cs_n,
    input logic       spi_do,
    input logic       spi_do_oe,
    input logic       wb_valid_o,
    input logic       cmd_valid_o,
    input logic [2:0] cmd_class_o
);
    localparam int HI_LIMIT = SYNC_STAGES + 3;

    logic [3:0] cs_hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)                           cs_hi_cnt <= '0;
        else if (!spi_cs_n)                cs_hi_cnt <= '0;
        else if (cs_hi_cnt != 4'hF)        cs_hi_cnt <= cs_hi_cnt + 4'd1;
    end

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |=> !cmd_valid_o); // R2

    AST_DO_QUIET: assert property (@(posedge clk) disable iff (rst)
        !spi_do_oe |-> !spi_do); // R12

    AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        (32'(cs_hi_cnt) >= HI_LIMIT) |-> !spi_do_oe); // R12

    AST_WB_APART: assert property (@(posedge clk) disable iff (rst)
        wb_valid_o |-> !cmd_valid_o); // R9

    AST_CLASS_KNOWN: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |-> (cmd_class_o != 3'd0 && cmd_class_o != 3'd7)); // R11
endmodule

bind flash_cmd_frontend flash_cmd_frontend_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_do(spi_do),
    .spi_do_oe(spi_do_oe), .wb_valid_o(wb_valid_o),
    .cmd_valid_o(cmd_valid_o), .cmd_class_o(cmd_class_o)
);

// File: tb/flash_cmd_frontend_tb.sv
module flash_cmd_frontend_tb;
    localparam int HALF  = 8;
    localparam int CNT_W = 12;
    localparam logic [7:0] ST1 = 8'hC3;
    localparam logic [7:0] ST2 = 8'h5E;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_di = 1'b0;
    logic spi_do, spi_do_oe, busy_i = 1'b0;
    logic [23:0] rd_addr_o;
    logic [7:0] rd_data_i;
    logic wb_valid_o, cmd_valid_o;
    logic [7:0] wb_data_o, cmd_op_o;
    logic [2:0] cmd_class_o;
    logic [23:0] cmd_addr_o;
    logic [CNT_W-1:0] cmd_nbytes_o;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] memv(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction
    assign rd_data_i = memv(rd_addr_o);

    flash_cmd_frontend #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_di(spi_di), .spi_do(spi_do), .spi_do_oe(spi_do_oe),
        .busy_i(busy_i), .status1_i(ST1), .status2_i(ST2),
        .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
        .wb_valid_o(wb_valid_o), .wb_data_o(wb_data_o),
        .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o),
        .cmd_class_o(cmd_class_o), .cmd_addr_o(cmd_addr_o),
        .cmd_nbytes_o(cmd_nbytes_o)
    );

    typedef struct {
        logic [7:0]  op;
        logic [2:0]  cls;
        logic [23:0] addr;
        int          nb;
        string       tag;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] wb_q[$];
    int checks = 0, errors = 0, unexpected = 0, oe_cnt = 0;
    bit done = 1'b0;
    logic [7:0] txb [0:15];
    logic       rxb [0:255];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Monitor: pops scoreboard items as the design produces them
    always @(negedge clk) begin
        if (!rst && spi_do_oe) oe_cnt++;
        if (!rst && cmd_valid_o) begin
            if (exp_q.size() == 0) unexpected++;
            else begin
                exp_t e;
                e = exp_q.pop_front();
                check(cmd_op_o == e.op, e.tag, "opcode", cmd_op_o, e.op);
                check(cmd_class_o == e.cls, e.tag, "class", cmd_class_o, e.cls);
                check(cmd_addr_o == e.addr, e.tag, "address", cmd_addr_o, e.addr);
                check(int'(cmd_nbytes_o) == e.nb, e.tag, "byte count", cmd_nbytes_o, e.nb);
                check(wb_q.size() == 0, "R9", "payload before strobe", wb_q.size(), 0);
            end
        end
        if (!rst && wb_valid_o) begin
            if (wb_q.size() == 0) unexpected++;
            else begin
                logic [7:0] b;
                b = wb_q.pop_front();
                check(wb_data_o == b, "R9", "payload byte", wb_data_o, b);
            end
        end
    end

    task automatic expect_cmd(input logic [7:0] op, input logic [2:0] cls,
                              input logic [23:0] addr, input int nb, input string tag);
        exp_t e;
        e.op = op; e.cls = cls; e.addr = addr; e.nb = nb; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic frame(input bit m3, input int nbits, input int tail);
        @(negedge clk);
        spi_sclk = m3;
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            spi_sclk = 1'b0;
            spi_di   = txb[i/8][7-(i%8)];
            repeat (HALF) @(negedge clk);
            rxb[i]   = spi_do;
            spi_sclk = 1'b1;
            repeat ((m3 && i == nbits-1) ? tail : HALF) @(negedge clk);
        end
        if (!m3) begin
            spi_sclk = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        spi_cs_n = 1'b1;
        spi_di   = 1'b0;
        repeat (16) @(negedge clk);
    endtask

    function automatic logic [7:0] rx_byte(input int k);
        logic [7:0] v;
        for (int b = 0; b < 8; b++) v[7-b] = rxb[8*k+b];
        return v;
    endfunction

    task automatic set_tx(input logic [7:0] b0, b1, b2, b3, b4, b5, b6);
        for (int i = 0; i < 16; i++) txb[i] = 8'h00;
        txb[0] = b0; txb[1] = b1; txb[2] = b2; txb[3] = b3;
        txb[4] = b4; txb[5] = b5; txb[6] = b6;
    endtask

    task automatic settle(input string req);
        check(exp_q.size() == 0, req, "missing command strobe", exp_q.size(), 0);
        check(wb_q.size() == 0, req, "missing payload pulse", wb_q.size(), 0);
        check(unexpected == 0, req, "unexpected strobe", unexpected, 0);
    endtask

    initial begin
        int oe_base;
        repeat (10) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!spi_do && !spi_do_oe && !wb_valid_o && !cmd_valid_o, "R1", "outputs after reset",
              {spi_do, spi_do_oe, wb_valid_o, cmd_valid_o}, 0);
        check(rd_addr_o == 24'h0, "R1", "rd_addr after reset", rd_addr_o, 0);

        // R5 R4 mode 0 plain read, three data bytes
        set_tx(8'h03, 8'h12, 8'h34, 8'h56, 0, 0, 0);
        expect_cmd(8'h03, 3'd1, 24'h123456, 3, "R2");
        frame(1'b0, 56, HALF);
        for (int j = 0; j < 3; j++)
            check(rx_byte(4+j) == memv(24'h123456 + 24'(j)), "R5", "read data mode0",
                  rx_byte(4+j), memv(24'h123456 + 24'(j)));
        settle("R2");

        // R3 R4 mode 3 fast read with address wrap
        set_tx(8'h0B, 8'hFF, 8'hFF, 8'hFE, 8'h00, 0, 0);
        expect_cmd(8'h0B, 3'd1, 24'hFFFFFE, 3, "R3");
        frame(1'b1, 64, HALF);
        for (int j = 0; j < 3; j++)
            check(rx_byte(5+j) == memv(24'hFFFFFE + 24'(j)), "R4", "fast read wrap mode3",
                  rx_byte(5+j), memv(24'hFFFFFE + 24'(j)));
        settle("R3");

        // R7 read ending mid-byte is still accepted
        set_tx(8'h03, 8'h00, 8'h00, 8'h10, 0, 0, 0);
        expect_cmd(8'h03, 3'd1, 24'h000010, 1, "R7");
        frame(1'b0, 43, HALF);
        check(rx_byte(4) == memv(24'h10), "R7", "read data before cut", rx_byte(4), memv(24'h10));
        settle("R7");

        // R6 status reads
        set_tx(8'h05, 0, 0, 0, 0, 0, 0);
        expect_cmd(8'h05, 3'd2, 24'h0, 2, "R6");
        frame(1'b0, 24, HALF);
        check(rx_byte(1) == ST1 && rx_byte(2) == ST1, "R6", "status1 repeated", {rx_byte(1), rx_byte(2)}, {ST1, ST1});
        set_tx(8'h35, 0, 0, 0, 0, 0, 0);
        expect_cmd(8'h35, 3'd2, 24'h0, 1, "R6");
        frame(1'b1, 16, HALF);
        check(rx_byte(1) == ST2, "R6", "status2 mode3", rx_byte(1), ST2);
        settle("R6");

        // R9 program, mode 3, normal tail
        set_tx(8'h02, 8'h00, 8'hAB, 8'h00, 8'h11, 8'h22, 8'h33);
        wb_q.push_back(8'h11); wb_q.push_back(8'h22); wb_q.push_back(8'h33);
        expect_cmd(8'h02, 3'd4, 24'h00AB00, 3, "R9");
        oe_base = oe_cnt;
        frame(1'b1, 56, HALF);
        check(oe_cnt == oe_base, "R12", "no drive during program", oe_cnt - oe_base, 0);
        settle("R9");

        // R9 chip select rises one system clock after the last rising edge
        set_tx(8'h02, 8'h00, 8'h00, 8'hC0, 8'h9A, 8'hBC, 0);
        wb_q.push_back(8'h9A); wb_q.push_back(8'hBC);
        expect_cmd(8'h02, 3'd4, 24'h0000C0, 2, "R9");
        frame(1'b1, 48, 1);
        settle("R9");

        // R8 program ending on a partial byte
        set_tx(8'h02, 8'h00, 8'h01, 8'h00, 8'h44, 8'h55, 8'h66);
        wb_q.push_back(8'h44); wb_q.push_back(8'h55);
        frame(1'b0, 53, HALF);
        settle("R8");

        // R2 R4 erase with and without address
        set_tx(8'h20, 8'h00, 8'h10, 8'h00, 0, 0, 0);
        expect_cmd(8'h20, 3'd5, 24'h001000, 0, "R4");
        frame(1'b0, 32, HALF);
        set_tx(8'hC7, 0, 0, 0, 0, 0, 0);
        expect_cmd(8'hC7, 3'd5, 24'h0, 0, "R2");
        frame(1'b1, 8, HALF);
        settle("R2");

        // R8 erase with short header, control frame one bit long
        set_tx(8'h20, 8'h00, 8'h10, 0, 0, 0, 0);
        frame(1'b0, 24, HALF);
        settle("R8");
        set_tx(8'h06, 0, 0, 0, 0, 0, 0);
        expect_cmd(8'h06, 3'd6, 24'h0, 0, "R2");
        frame(1'b0, 8, HALF);
        frame(1'b0, 9, HALF);
        settle("R8");

        // R10 busy lockout
        busy_i = 1'b1;
        set_tx(8'h02, 8'h00, 8'h02, 8'h00, 8'h77, 8'h88, 0);
        oe_base = oe_cnt;
        frame(1'b0, 48, HALF);
        settle("R10");
        set_tx(8'h03, 8'h00, 8'h00, 8'h20, 0, 0, 0);
        frame(1'b1, 48, HALF);
        check(oe_cnt == oe_base, "R10", "read drive while busy", oe_cnt - oe_base, 0);
        set_tx(8'h05, 0, 0, 0, 0, 0, 0);
        expect_cmd(8'h05, 3'd2, 24'h0, 1, "R10");
        frame(1'b0, 16, HALF);
        check(rx_byte(1) == ST1, "R10", "status1 while busy", rx_byte(1), ST1);
        settle("R10");
        busy_i = 1'b0;

        // R11 unknown opcode
        set_tx(8'h9F, 0, 0, 0, 0, 0, 0);
        oe_base = oe_cnt;
        frame(1'b0, 32, HALF);
        check(oe_cnt == oe_base, "R11", "drive on unknown opcode", oe_cnt - oe_base, 0);
        settle("R11");

        // R12 idle after frames
        check(!spi_do_oe && !spi_do, "R12", "idle data out", {spi_do_oe, spi_do}, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule